// File: doc/BRIEF.md
# Half-Rate Interleaved Instruction Bank Array

This block holds the instruction words and the per-set tags of an instruction cache. Both are spread over small storage banks. Each bank needs two core cycles for one access. The data words are spread over `N_BANKS` banks, each one instruction word wide. Word `w` of the cache-local word address space lives in bank `w mod N_BANKS`, so consecutive fetch words fall into neighbouring banks. The tags live in two banks, and the lowest bit of the set index picks between them.

The core clock drives every bank. A phase input toggles from one core cycle to the next and stands in for the half-rate bank clock. Even data banks and tag bank 0 may start an access only when the phase is 0. Odd data banks and tag bank 1 may start only when the phase is 1. A sequential stream that starts in step with the phase therefore alternates between the two groups and gets one word back every core cycle.

A request that cannot start in its data bank is flagged as a phase conflict in the same cycle, so that an external controller can replay it. Hit/miss comparison, refill sequencing and replay control sit outside this block. The write side of the request port lets that outside logic fill the banks. The bank count must be a power of two and at least 2, and other values stop elaboration.

Top module: `hb_array`

## Requirements
- R1: After reset is released, and before any request is accepted, `rd_valid`, `tag_valid` and every bit of `bank_busy` are 0.
- R2: The data bank is `req_waddr[BSEL_W-1:0]`, where BSEL_W = log2(N_BANKS) and is 2 by default. The row inside that bank is the remaining upper bits of `req_waddr`. A read returns the word last written to that bank and row.
- R3: Data bank `b` can accept a request only in a cycle where `phase` equals `b mod 2`. Tag bank `t` can accept a request only in a cycle where `phase` equals `t`.
- R4: A read that its data bank accepts in cycle t raises `rd_valid`, with the word on `rd_data`, in cycle t+2 and in no other cycle. Writes never raise `rd_valid`.
- R5: `bank_busy[b]` is 1 in exactly the cycle after bank `b` accepts a request. A request to a data bank that is busy is not accepted, whatever the phase.
- R6: `req_conflict` is 1 in the same cycle whenever `req_valid` is 1 and the target data bank does not accept the request. A rejected write changes no data word, and a rejected read produces no output.
- R7: A read stream of consecutive word addresses, with `phase` toggling every cycle and the first address in step with the phase, has no conflicts and yields one `rd_valid` per core cycle.
- R8: The tag bank is bit log2(LINE_WORDS) of `req_waddr`, which is bit 2 by default. The tag row is the bits above it. A read that its tag bank accepts in cycle t raises `tag_valid`, with the stored tag on `rd_tag`, in cycle t+2. The tag bank accepts or rejects independently of the data bank.
- R9: A write that its data bank accepts stores `req_wdata` in the data bank. If its tag bank also accepts it in that cycle, it stores `req_wtag` as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write (fill), 0 = read |
| req_waddr | input | SET_W+log2(LINE_WORDS) | Cache-local word address |
| req_wdata | input | LBW | Instruction word to store |
| req_wtag | input | TAG_W | Tag to store for the addressed set |
| phase | input | 1 | Half-rate phase, expected to toggle every core cycle |
| req_conflict | output | 1 | Request not accepted by its data bank |
| rd_valid | output | 1 | Instruction word valid |
| rd_data | output | LBW | Instruction word |
| tag_valid | output | 1 | Tag word valid |
| rd_tag | output | TAG_W | Tag word |
| bank_busy | output | N_BANKS | Per-data-bank second-cycle indication |

## Verification
The assertions take for granted that every input is at a known value while reset is released. They also assume that the request fields are sampled only at the clock edge, so a glitch between edges has no meaning. Nothing is assumed about `phase`: the properties hold even when it stalls. The stimulus changes inputs only half a period away from the active edge and always drives defined values. Its random phase sequence sometimes holds the phase for a cycle, so both the phase rule and the busy rule are stressed under legal inputs.

// File: rtl/hb_pkg.sv
package hb_pkg;

    // Launch group of a bank: which phase value lets it start an access.
    typedef enum logic {
        GRP_EVEN = 1'b0,
        GRP_ODD  = 1'b1
    } hb_grp_e;

    function automatic hb_grp_e grp_of(input int idx);
        return (idx % 2 == 0) ? GRP_EVEN : GRP_ODD;
    endfunction

endpackage

// File: rtl/hb_decode.sv
module hb_decode #(
    parameter int N_BANKS    = 4,
    parameter int SET_W      = 4,
    parameter int LINE_WORDS = 4,
    localparam int LW_BITS   = $clog2(LINE_WORDS),
    localparam int WADDR_W   = SET_W + LW_BITS,
    localparam int BSEL_W    = $clog2(N_BANKS),
    localparam int DROW_W    = WADDR_W - BSEL_W,
    localparam int TROW_W    = SET_W - 1
) (
    input  logic [WADDR_W-1:0] waddr,
    output logic [BSEL_W-1:0]  dbank,
    output logic [DROW_W-1:0]  drow,
    output logic               tbank,
    output logic [TROW_W-1:0]  trow
);

    // Word interleave: low bits pick the data bank, the rest the row.
    assign dbank = waddr[BSEL_W-1:0];
    assign drow  = waddr[WADDR_W-1:BSEL_W];

    // Lowest set-index bit picks the tag bank, upper set bits the row.
    assign tbank = waddr[LW_BITS];
    assign trow  = waddr[WADDR_W-1:LW_BITS+1];

endmodule

// File: rtl/hb_bank.sv
module hb_bank
    import hb_pkg::*;
#(
    parameter int      W      = 32,
    parameter int      DEPTH  = 16,
    parameter hb_grp_e GROUP  = GRP_EVEN,
    localparam int     ROW_W  = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase,
    input  logic             start,
    input  logic             wr,
    input  logic [ROW_W-1:0] row,
    input  logic [W-1:0]     wdata,
    output logic             accept,
    output logic             busy,
    output logic             done,
    output logic [W-1:0]     rdata
);

    typedef struct packed {
        logic             busy;
        logic             rd;
        logic [ROW_W-1:0] row;
        logic             done;
        logic [W-1:0]     data;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];

    always_comb begin
        accept  = start && (phase == logic'(GROUP)) && !st_q.busy;
        st_d    = st_q;
        st_d.busy = accept;
        st_d.rd   = accept && !wr;
        if (accept) begin
            st_d.row = row;
        end
        // second cycle of a read: array output is captured
        st_d.done = st_q.busy && st_q.rd;
        if (st_q.busy && st_q.rd) begin
            st_d.data = mem[st_q.row];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (accept && wr) begin
            mem[row] <= wdata;
        end
    end

    assign busy  = st_q.busy;
    assign done  = st_q.done;
    assign rdata = st_q.data;

endmodule

// File: rtl/hb_array.sv
module hb_array
    import hb_pkg::*;
#(
    parameter int  N_BANKS    = 4,
    parameter int  LBW        = 32,
    parameter int  TAG_W      = 20,
    parameter int  SET_W      = 4,
    parameter int  LINE_WORDS = 4,
    localparam int WADDR_W    = SET_W + $clog2(LINE_WORDS),
    localparam int BSEL_W     = $clog2(N_BANKS),
    localparam int DROW_W     = WADDR_W - BSEL_W,
    localparam int DDEPTH     = 1 << DROW_W,
    localparam int TROW_W     = SET_W - 1,
    localparam int TDEPTH     = 1 << TROW_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [WADDR_W-1:0] req_waddr,
    input  logic [LBW-1:0]     req_wdata,
    input  logic [TAG_W-1:0]   req_wtag,
    input  logic               phase,
    output logic               req_conflict,
    output logic               rd_valid,
    output logic [LBW-1:0]     rd_data,
    output logic               tag_valid,
    output logic [TAG_W-1:0]   rd_tag,
    output logic [N_BANKS-1:0] bank_busy
);

    if (N_BANKS < 2 || (1 << BSEL_W) != N_BANKS) begin : g_bad_bank_count
        $error("hb_array: N_BANKS must be a power of two and at least 2");
    end

    logic [BSEL_W-1:0] dbank;
    logic [DROW_W-1:0] drow;
    logic              tbank;
    logic [TROW_W-1:0] trow;

    hb_decode #(
        .N_BANKS   (N_BANKS),
        .SET_W     (SET_W),
        .LINE_WORDS(LINE_WORDS)
    ) u_decode (
        .waddr(req_waddr),
        .dbank(dbank),
        .drow (drow),
        .tbank(tbank),
        .trow (trow)
    );

    logic [N_BANKS-1:0] d_acc, d_done;
    logic [LBW-1:0]     d_rdata [N_BANKS];
    logic [1:0]         t_acc, t_busy, t_done;
    logic [TAG_W-1:0]   t_rdata [2];

    for (genvar b = 0; b < N_BANKS; b++) begin : g_data
        hb_bank #(
            .W    (LBW),
            .DEPTH(DDEPTH),
            .GROUP(grp_of(b))
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .phase (phase),
            .start (req_valid && (dbank == BSEL_W'(b))),
            .wr    (req_write),
            .row   (drow),
            .wdata (req_wdata),
            .accept(d_acc[b]),
            .busy  (bank_busy[b]),
            .done  (d_done[b]),
            .rdata (d_rdata[b])
        );
    end

    for (genvar t = 0; t < 2; t++) begin : g_tag
        hb_bank #(
            .W    (TAG_W),
            .DEPTH(TDEPTH),
            .GROUP(grp_of(t))
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .phase (phase),
            .start (req_valid && (tbank == 1'(t))),
            .wr    (req_write),
            .row   (trow),
            .wdata (req_wtag),
            .accept(t_acc[t]),
            .busy  (t_busy[t]),
            .done  (t_done[t]),
            .rdata (t_rdata[t])
        );
    end

    assign req_conflict = req_valid && !(|d_acc);

    // At most one bank of each kind finishes per cycle: OR-select.
    always_comb begin
        rd_valid = |d_done;
        rd_data  = '0;
        for (int b = 0; b < N_BANKS; b++) begin
            if (d_done[b]) begin
                rd_data = rd_data | d_rdata[b];
            end
        end
        tag_valid = |t_done;
        rd_tag    = '0;
        for (int t = 0; t < 2; t++) begin
            if (t_done[t]) begin
                rd_tag = rd_tag | t_rdata[t];
            end
        end
    end

endmodule

// File: rtl/hb_array_chk.sv
module hb_array_chk #(
    parameter int N_BANKS = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_write,
    input logic               phase,
    input logic               req_conflict,
    input logic               rd_valid,
    input logic               tag_valid,
    input logic [N_BANKS-1:0] bank_busy
);

    function automatic logic [N_BANKS-1:0] even_mask();
        logic [N_BANKS-1:0] m;
        for (int i = 0; i < N_BANKS; i++) begin
            m[i] = (i % 2 == 0);
        end
        return m;
    endfunction

    localparam logic [N_BANKS-1:0] EVEN_M = even_mask();

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!rd_valid && !tag_valid && bank_busy == '0));

    assert_even_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(bank_busy & EVEN_M)) |-> ($past(phase) == 1'b0));

    assert_odd_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(bank_busy & ~EVEN_M)) |-> ($past(phase) == 1'b1));

    assert_rd_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && !req_conflict && !req_write, 2));

    assert_busy_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_busy));

    assert_accept_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_conflict) |=> ($countones(bank_busy) == 1));

    assert_reject_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_conflict) |=> (bank_busy == '0));

    assert_tag_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tag_valid |-> $past(req_valid && !req_write, 2));

endmodule

bind hb_array hb_array_chk #(.N_BANKS(N_BANKS)) u_chk (.*);

// File: tb/hb_array_tb.sv
module hb_array_tb;

    localparam int NB  = 4;
    localparam int LW  = 4;
    localparam int DW  = 32;
    localparam int TW  = 20;
    localparam int AW  = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_waddr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [TW-1:0] req_wtag = '0;
    logic          phase = 1'b0;
    logic          req_conflict, rd_valid, tag_valid;
    logic [DW-1:0] rd_data;
    logic [TW-1:0] rd_tag;
    logic [NB-1:0] bank_busy;

    always #4 clk = ~clk;

    hb_array #(.N_BANKS(NB), .LBW(DW), .TAG_W(TW), .SET_W(4), .LINE_WORDS(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_waddr(req_waddr), .req_wdata(req_wdata), .req_wtag(req_wtag),
        .phase(phase), .req_conflict(req_conflict), .rd_valid(rd_valid),
        .rd_data(rd_data), .tag_valid(tag_valid), .rd_tag(rd_tag),
        .bank_busy(bank_busy)
    );

    int total = 0;
    int bad = 0;
    int seq_cnt = 0;
    int conf_cnt = 0;

    // reference model state
    logic [DW-1:0] dm [NB][16];
    logic [TW-1:0] tm [2][8];
    bit e1_v, e1_rd, e2_v, t1_v, t1_rd, t2_v;
    int e1_bk, e1_rw, t1_bk, t1_rw;
    logic [DW-1:0] e2_d;
    logic [TW-1:0] t2_d;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input bit v, input bit w, input int wa, input logic [DW-1:0] wd,
                       input logic [TW-1:0] wt, input bit ph);
        int bk, rw, tb, tr;
        bit acc, tacc;
        logic [NB-1:0] exp_busy;
        req_valid = v; req_write = w; req_waddr = AW'(wa);
        req_wdata = wd; req_wtag = wt; phase = ph;
        #1;
        bk = wa % NB; rw = wa / NB; tb = (wa / LW) % 2; tr = wa / (2 * LW);
        acc  = v && (int'(ph) == bk % 2) && !(e1_v && e1_bk == bk);
        tacc = v && (int'(ph) == tb) && !(t1_v && t1_bk == tb);
        exp_busy = e1_v ? NB'(1 << e1_bk) : '0;
        chk(req_conflict === (v && !acc), "R6 conflict", 64'(req_conflict), 64'(v && !acc));
        chk(bank_busy === exp_busy, "R5 bank_busy", 64'(bank_busy), 64'(exp_busy));
        chk(rd_valid === e2_v, "R4 rd_valid", 64'(rd_valid), 64'(e2_v));
        if (e2_v) chk(rd_data === e2_d, "R2 rd_data", 64'(rd_data), 64'(e2_d));
        chk(tag_valid === t2_v, "R8 tag_valid", 64'(tag_valid), 64'(t2_v));
        if (t2_v) chk(rd_tag === t2_d, "R8 rd_tag", 64'(rd_tag), 64'(t2_d));
        if (rd_valid === 1'b1) seq_cnt++;
        if (req_conflict === 1'b1) conf_cnt++;
        // advance model across the coming edge (reads before this cycle's write)
        e2_v = e1_v && e1_rd;
        if (e2_v) e2_d = dm[e1_bk][e1_rw];
        t2_v = t1_v && t1_rd;
        if (t2_v) t2_d = tm[t1_bk][t1_rw];
        e1_v = acc; e1_rd = !w; e1_bk = bk; e1_rw = rw;
        t1_v = tacc; t1_rd = !w; t1_bk = tb; t1_rw = tr;
        if (acc && w) dm[bk][rw] = wd;      // R9
        if (tacc && w) tm[tb][tr] = wt;     // R9
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #800000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        bit ph;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: quiet after reset
        chk(rd_valid === 1'b0, "R1 rd_valid", 64'(rd_valid), 64'd0);
        chk(tag_valid === 1'b0, "R1 tag_valid", 64'(tag_valid), 64'd0);
        chk(bank_busy === '0, "R1 bank_busy", 64'(bank_busy), 64'd0);
        @(negedge clk);

        // R9 fill: aligned sequential writes
        for (int w = 0; w < 64; w++) begin
            cyc(1'b1, 1'b1, w, 32'h5A00_0000 ^ (w * 32'h0103_0507), TW'(20'hA0000 + w / LW), 1'(w % 2));
        end
        cyc(1'b0, 1'b0, 0, '0, '0, 1'b0);
        cyc(1'b0, 1'b0, 0, '0, '0, 1'b1);

        // R7: sequential read stream, one word per cycle
        seq_cnt = 0; conf_cnt = 0;
        for (int i = 0; i < 24; i++) begin
            cyc(1'b1, 1'b0, 8 + i, '0, '0, 1'(i % 2));
        end
        cyc(1'b0, 1'b0, 0, '0, '0, 1'b0);
        cyc(1'b0, 1'b0, 0, '0, '0, 1'b1);
        chk(seq_cnt == 24, "R7 words returned", 64'(seq_cnt), 64'd24);
        chk(conf_cnt == 0, "R7 conflicts", 64'(conf_cnt), 64'd0);

        // R3: odd bank with phase 0 is rejected
        cyc(1'b1, 1'b0, 1, '0, '0, 1'b0);
        cyc(1'b0, 1'b0, 0, '0, '0, 1'b1);
        // R5: same bank twice with phase held -> second rejected; other even bank accepted
        cyc(1'b1, 1'b0, 0, '0, '0, 1'b0);
        cyc(1'b1, 1'b0, 4, '0, '0, 1'b0);
        cyc(1'b1, 1'b0, 2, '0, '0, 1'b0);
        cyc(1'b0, 1'b0, 0, '0, '0, 1'b1);
        // R6: rejected write leaves word 5 intact, read it back
        cyc(1'b1, 1'b1, 5, 32'hDEAD_BEEF, 20'h0BAD0, 1'b0);
        cyc(1'b1, 1'b0, 5, '0, '0, 1'b1);
        cyc(1'b0, 1'b0, 0, '0, '0, 1'b0);
        cyc(1'b0, 1'b0, 0, '0, '0, 1'b1);
        // R8: data accepted while tag bank rejects on phase
        cyc(1'b1, 1'b0, 1, '0, '0, 1'b1);
        cyc(1'b0, 1'b0, 0, '0, '0, 1'b0);
        cyc(1'b0, 1'b0, 0, '0, '0, 1'b1);

        // mixed traffic, phase occasionally stalled
        ph = 1'b0;
        void'($urandom(32'd7));
        for (int i = 0; i < 4000; i++) begin
            ph = ($urandom % 8 == 0) ? ph : !ph;
            cyc(($urandom % 4) != 0, ($urandom % 8) == 0, int'($urandom % 64),
                $urandom, TW'($urandom), ph);
        end
        cyc(1'b0, 1'b0, 0, '0, '0, 1'b0);
        cyc(1'b0, 1'b0, 0, '0, '0, 1'b1);
        finish_run();
    end

endmodule